// File: doc/BRIEF.md
# Priority Interrupt Controller Core

This block collects a set of interrupt inputs and decides when to raise one interrupt request toward a processor. Each input has its own configuration word: a mask bit, a 4-bit priority (0 lowest, 15 highest), a vector number and a sense mode, which is either edge or level. Software sets a current-task threshold. The request line is raised only when the best unmasked pending input is strictly above that threshold and strictly above every input already in service.

Software works through a small word-addressed register port. It writes the threshold, the spurious vector and the per-input configuration words. It reads an acknowledge register to take the winning vector, and it writes an end-of-interrupt register to retire the most urgent in-service entry. An acknowledge has side effects. It clears an edge input's pending flag, adds the input to the in-service set and drops the request line. An acknowledge with nothing eligible returns the spurious vector and changes no state.

The request line comes from a three-state machine. In S_IDLE the line is low. The transition IDLE_TO_REQ is taken when a candidate becomes eligible, and the line is high in S_REQ. REQ_TO_IDLE is taken if the candidate stops being eligible. ANY_TO_SETTLE is taken on an acknowledge that hits an eligible candidate. S_SETTLE holds the line low for one cycle, and SETTLE_TO_IDLE is taken unconditionally, after which the line is evaluated again.

Top module: `pic_top`

## Requirements
- R1: After reset, irq is low, the threshold (word 0) reads 0x0000000F, the spurious vector (word 3) reads 0xFF and every configuration word reads 0x80000000, meaning masked.
- R2: The threshold is held in bits 3..0 of word 0. Bits 31..4 read as zero whatever was written. Read data and reg_rvalid appear one cycle after the reg_rd strobe.
- R3: With the threshold at 15, irq never rises, even for a priority-15 input.
- R4: irq rises on the second clock edge after a qualifying input event. It rises only if the best candidate's priority is strictly greater than the threshold and strictly greater than the highest in-service priority.
- R5: Among pending unmasked inputs, the highest priority wins. Ties go to the lowest input index.
- R6: A read of word 1 (acknowledge) returns the winner's vector in bits 7..0, clears irq in the following cycle and puts the winner in service. An in-service input then blocks inputs of equal or lower priority.
- R7: Configuration word bit 16 selects the sense: 0 for edge (a rising input sets pending), 1 for level (pending follows the input). An acknowledge clears an edge input's pending flag. A level input stays pending while its input is high.
- R8: An acknowledge with no eligible candidate returns the spurious vector (word 3, bits 7..0) and leaves the pending and in-service state unchanged.
- R9: Writes to word 1 have no effect.
- R10: Writing word 4 with bit 0 set returns the threshold to 15.
- R11: Any write to word 2 (end-of-interrupt) removes the highest-priority in-service entry. irq is then evaluated again in the next cycle.
- R12: Configuration words start at word 8 for input 0. They hold the vector in bits 7..0, the priority in bits 11..8 and the mask in bit 31. A masked input never raises irq and is never returned by an acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_in | input | N_SRC | Interrupt inputs, one bit per source |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, registered |
| reg_rvalid | output | 1 | Read data valid, one cycle after reg_rd |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The directed scenarios target the tie between two equal-priority inputs. A design that broke ties toward the higher index would return the wrong vector there. A nested case acknowledges a low input, then a higher one, then retires one entry. If the design retired the oldest entry instead of the most urgent, irq would stay low for a third input that ought to preempt. Further scenarios cover an input whose priority equals the threshold and the full mask at 15. In both, a comparison written as greater-or-equal would raise irq where it must stay low. A level input is acknowledged while its line stays high and should come back, and an edge input should not. A spurious acknowledge is expected to leave a blocked pending input intact, so that lowering the threshold afterwards still raises irq.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PRIO_W = 4;

    // Word offsets on the register port
    localparam int OFF_TASK   = 0;
    localparam int OFF_ACK    = 1;
    localparam int OFF_EOI    = 2;
    localparam int OFF_SPUR   = 3;
    localparam int OFF_REINIT = 4;
    localparam int OFF_SRC    = 8;

    // Field positions inside a source configuration word
    localparam int CFG_VEC_LSB   = 0;
    localparam int CFG_PRIO_LSB  = 8;
    localparam int CFG_LEVEL_BIT = 16;
    localparam int CFG_MASK_BIT  = 31;

    typedef logic [PRIO_W-1:0] prio_t;
    localparam prio_t PRIO_MAX = '1;

    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_REQ    = 2'd1,
        S_SETTLE = 2'd2
    } irq_state_e;

    typedef struct packed {
        logic  masked;
        logic  level;
        prio_t prio;
    } src_ctl_t;
endpackage

// File: rtl/pic_arbiter.sv
module pic_arbiter
    import pic_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic [N-1:0]       req,
    input  prio_t [N-1:0]      prio,
    output logic               found,
    output logic [IDX_W-1:0]   idx,
    output prio_t              best
);
    // Strict comparison while scanning upward keeps the lowest index on ties
    always_comb begin
        found = 1'b0;
        idx   = '0;
        best  = '0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && (!found || prio[i] > best)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
                best  = prio[i];
            end
        end
    end
endmodule

// File: rtl/pic_src_slice.sv
module pic_src_slice
    import pic_pkg::*;
#(
    parameter int VEC_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [DATA_W-1:0] cfg_wdata,
    input  logic              src_in,
    input  logic              ack_take,
    output logic              pend,
    output src_ctl_t          ctl,
    output logic [VEC_W-1:0]  vec,
    output logic [DATA_W-1:0] cfg_rdata
);
    src_ctl_t         ctl_q;
    logic [VEC_W-1:0] vec_q;
    logic             src_q;
    logic             pend_q;
    logic             unused_cfg_bits;

    assign unused_cfg_bits = ^cfg_wdata;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q.masked <= 1'b1;
            ctl_q.level  <= 1'b0;
            ctl_q.prio   <= '0;
            vec_q        <= '0;
            src_q        <= 1'b0;
            pend_q       <= 1'b0;
        end else begin
            if (cfg_we) begin
                ctl_q.masked <= cfg_wdata[CFG_MASK_BIT];
                ctl_q.level  <= cfg_wdata[CFG_LEVEL_BIT];
                ctl_q.prio   <= cfg_wdata[CFG_PRIO_LSB +: PRIO_W];
                vec_q        <= cfg_wdata[CFG_VEC_LSB +: VEC_W];
            end
            src_q <= src_in;
            if (ctl_q.level) begin
                pend_q <= src_in;
            end else if (src_in && !src_q) begin
                pend_q <= 1'b1;
            end else if (ack_take) begin
                pend_q <= 1'b0;
            end
        end
    end

    always_comb begin
        cfg_rdata                              = '0;
        cfg_rdata[CFG_MASK_BIT]                = ctl_q.masked;
        cfg_rdata[CFG_LEVEL_BIT]               = ctl_q.level;
        cfg_rdata[CFG_PRIO_LSB +: PRIO_W]      = ctl_q.prio;
        cfg_rdata[CFG_VEC_LSB +: VEC_W]        = vec_q;
    end

    assign pend = pend_q;
    assign ctl  = ctl_q;
    assign vec  = vec_q;
endmodule

// File: rtl/pic_service.sv
module pic_service
    import pic_pkg::*;
#(
    parameter int N     = 8,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [IDX_W-1:0]  push_idx,
    input  logic              pop,
    input  prio_t [N-1:0]     prio,
    output logic [N-1:0]      isr,
    output logic              active,
    output prio_t             top_prio
);
    logic [N-1:0]     isr_q;
    logic [N-1:0]     isr_d;
    logic [IDX_W-1:0] top_idx;

    pic_arbiter #(.N(N), .IDX_W(IDX_W)) i_top_pick (
        .req   (isr_q),
        .prio  (prio),
        .found (active),
        .idx   (top_idx),
        .best  (top_prio)
    );

    always_comb begin
        isr_d = isr_q;
        if (pop && active) begin
            isr_d[top_idx] = 1'b0;
        end
        if (push) begin
            isr_d[push_idx] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            isr_q <= '0;
        end else begin
            isr_q <= isr_d;
        end
    end

    assign isr = isr_q;
endmodule

// File: rtl/pic_top.sv
module pic_top
    import pic_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int VEC_W  = 8,
    parameter int ADDR_W = 5,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_in,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              reg_rvalid,
    output logic              irq
);
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;
    localparam logic [ADDR_W-1:0] A_TASK   = ADDR_W'(OFF_TASK);
    localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFF_ACK);
    localparam logic [ADDR_W-1:0] A_EOI    = ADDR_W'(OFF_EOI);
    localparam logic [ADDR_W-1:0] A_SPUR   = ADDR_W'(OFF_SPUR);
    localparam logic [ADDR_W-1:0] A_REINIT = ADDR_W'(OFF_REINIT);

    // Software-visible state
    prio_t            task_q;
    logic [VEC_W-1:0] spur_q;

    // Per-source views
    logic [N_SRC-1:0]             pend_all;
    logic [N_SRC-1:0]             masked_all;
    prio_t [N_SRC-1:0]            prio_all;
    logic [N_SRC-1:0][VEC_W-1:0]  vec_all;
    logic [N_SRC-1:0][DATA_W-1:0] cfg_rd_all;
    logic [N_SRC-1:0]             cfg_we;
    logic [N_SRC-1:0]             ack_take;

    // Arbitration
    logic             best_found;
    logic [IDX_W-1:0] best_idx;
    prio_t            best_prio;
    logic [N_SRC-1:0] isr_bits;
    logic             isr_active;
    prio_t            isr_prio;
    logic             eligible;

    // Register strobes
    logic ack_rd;
    logic ack_fire;
    logic eoi_fire;

    // Read path
    logic [DATA_W-1:0] rd_d;
    logic [DATA_W-1:0] rdata_q;
    logic              rvalid_q;

    // Request state machine
    irq_state_e state_q;
    irq_state_e state_d;
    logic       irq_o;

    genvar g;
    generate
        for (g = 0; g < N_SRC; g++) begin : g_src
            src_ctl_t ctl_g;

            assign cfg_we[g]   = reg_wr && (reg_addr == ADDR_W'(OFF_SRC + g));
            assign ack_take[g] = ack_fire && (best_idx == IDX_W'(g));

            pic_src_slice #(.VEC_W(VEC_W), .DATA_W(DATA_W)) i_slice (
                .clk       (clk),
                .rst_n     (rst_n),
                .cfg_we    (cfg_we[g]),
                .cfg_wdata (reg_wdata),
                .src_in    (src_in[g]),
                .ack_take  (ack_take[g]),
                .pend      (pend_all[g]),
                .ctl       (ctl_g),
                .vec       (vec_all[g]),
                .cfg_rdata (cfg_rd_all[g])
            );

            assign masked_all[g] = ctl_g.masked;
            assign prio_all[g]   = ctl_g.prio;
        end
    endgenerate

    pic_arbiter #(.N(N_SRC), .IDX_W(IDX_W)) i_pend_pick (
        .req   (pend_all & ~masked_all),
        .prio  (prio_all),
        .found (best_found),
        .idx   (best_idx),
        .best  (best_prio)
    );

    pic_service #(.N(N_SRC), .IDX_W(IDX_W)) i_service (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (ack_fire),
        .push_idx (best_idx),
        .pop      (eoi_fire),
        .prio     (prio_all),
        .isr      (isr_bits),
        .active   (isr_active),
        .top_prio (isr_prio)
    );

    assign eligible = best_found && (best_prio > task_q)
                      && (!isr_active || (best_prio > isr_prio));
    assign ack_rd   = reg_rd && (reg_addr == A_ACK);
    assign ack_fire = ack_rd && eligible;
    assign eoi_fire = reg_wr && (reg_addr == A_EOI);

    // Threshold and spurious vector
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            task_q <= PRIO_MAX;
            spur_q <= '1;
        end else if (reg_wr) begin
            if (reg_addr == A_TASK) begin
                task_q <= reg_wdata[PRIO_W-1:0];
            end
            if (reg_addr == A_SPUR) begin
                spur_q <= reg_wdata[VEC_W-1:0];
            end
            if ((reg_addr == A_REINIT) && reg_wdata[0]) begin
                task_q <= PRIO_MAX;
            end
        end
    end

    // Read multiplexer
    always_comb begin
        rd_d = '0;
        if (reg_addr == A_TASK) begin
            rd_d[PRIO_W-1:0] = task_q;
        end else if (reg_addr == A_ACK) begin
            rd_d[VEC_W-1:0] = eligible ? vec_all[best_idx] : spur_q;
        end else if (reg_addr == A_SPUR) begin
            rd_d[VEC_W-1:0] = spur_q;
        end else begin
            for (int i = 0; i < N_SRC; i++) begin
                if (reg_addr == ADDR_W'(OFF_SRC + i)) begin
                    rd_d = cfg_rd_all[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= reg_rd;
            if (reg_rd) begin
                rdata_q <= rd_d;
            end
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        if (ack_fire) begin
            state_d = S_SETTLE;
        end else begin
            unique case (state_q)
                S_IDLE:   if (eligible) state_d = S_REQ;
                S_REQ:    if (!eligible) state_d = S_IDLE;
                S_SETTLE: state_d = S_IDLE;
                default:  state_d = S_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        irq_o = 1'b0;
        unique case (state_q)
            S_REQ:   irq_o = 1'b1;
            default: irq_o = 1'b0;
        endcase
    end

    assign irq        = irq_o;
    assign reg_rdata  = rdata_q;
    assign reg_rvalid = rvalid_q;
endmodule

// File: rtl/pic_checker.sv
module pic_checker
    import pic_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              irq,
    input logic              eligible,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic              reg_rvalid,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              wbit0,
    input prio_t             task_q,
    input logic [N_SRC-1:0]  isr_bits
);
    logic chk_ack_rd;
    logic chk_ack_hit;
    logic chk_eoi;
    logic chk_reinit;

    assign chk_ack_rd  = reg_rd && (reg_addr == ADDR_W'(OFF_ACK));
    assign chk_ack_hit = chk_ack_rd && eligible;
    assign chk_eoi     = reg_wr && (reg_addr == ADDR_W'(OFF_EOI));
    assign chk_reinit  = reg_wr && (reg_addr == ADDR_W'(OFF_REINIT)) && wbit0;

    assert_read_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> reg_rvalid);

    assert_full_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (task_q == PRIO_MAX && $past(task_q) == PRIO_MAX) |-> !irq);

    assert_irq_needs_winner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(eligible));

    assert_ack_drops_irq_R6: assert property (@(posedge clk) disable iff (!rst_n)
        chk_ack_hit |=> !irq);

    assert_ack_pushes_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_ack_hit && !chk_eoi) |=> ($countones(isr_bits) == $past($countones(isr_bits)) + 1));

    assert_spurious_keeps_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_ack_rd && !eligible && !reg_wr) |=> $stable(isr_bits));

    assert_reinit_task_R10: assert property (@(posedge clk) disable iff (!rst_n)
        chk_reinit |=> (task_q == PRIO_MAX));

    assert_eoi_pops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_eoi && !chk_ack_hit && (isr_bits != '0))
            |=> ($countones(isr_bits) == $past($countones(isr_bits)) - 1));
endmodule

bind pic_top pic_checker #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) i_pic_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .irq        (irq),
    .eligible   (eligible),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_rvalid (reg_rvalid),
    .reg_addr   (reg_addr),
    .wbit0      (reg_wdata[0]),
    .task_q     (task_q),
    .isr_bits   (isr_bits)
);

// File: tb/test_pic_top.sv
module test_pic_top;
    localparam int N_SRC  = 8;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [N_SRC-1:0]  src_in = '0;
    logic              reg_wr = 1'b0;
    logic              reg_rd = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic              reg_rvalid;
    logic              irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    pic_top #(.N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_pic_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_in     (src_in),
        .reg_wr     (reg_wr),
        .reg_rd     (reg_rd),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .irq        (irq)
    );

    localparam int W_TASK = 0, W_ACK = 1, W_EOI = 2, W_SPUR = 3, W_REINIT = 4, W_SRC = 8;

    function automatic logic [31:0] cfg(input bit masked, input bit level,
                                        input int prio, input int vec);
        cfg = {masked, 14'd0, level, 4'd0, prio[3:0], vec[7:0]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n  = 1'b0;
        src_in = '0;
        reg_wr = 1'b0;
        reg_rd = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int addr, input logic [31:0] data);
        reg_wr    = 1'b1;
        reg_addr  = ADDR_W'(addr);
        reg_wdata = data;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input int addr, output logic [31:0] data);
        reg_rd   = 1'b1;
        reg_addr = ADDR_W'(addr);
        @(negedge clk);
        reg_rd = 1'b0;
        data = reg_rvalid ? reg_rdata : 32'hDEAD_BEEF;
    endtask

    task automatic pulse(input logic [N_SRC-1:0] m);
        src_in = src_in | m;
        @(negedge clk);
        src_in = src_in & ~m;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        do_reset();
        check("R1 irq low", {31'd0, irq}, 32'd0);
        rd(W_TASK, d);  check("R1 threshold", d, 32'h0000_000F);
        rd(W_SPUR, d);  check("R1 spurious", d, 32'h0000_00FF);
        rd(W_SRC + 3, d); check("R1 config masked", d, 32'h8000_0000);
    endtask

    task automatic t_task_reg();
        logic [31:0] d;
        do_reset();
        wr(W_TASK, 32'hFFFF_FFA5);
        rd(W_TASK, d); check("R2 upper bits zero", d, 32'h0000_0005);
        wr(W_REINIT, 32'h1);
        rd(W_TASK, d); check("R10 reinit", d, 32'h0000_000F);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        do_reset();
        wr(W_SPUR, 32'hEE);
        wr(W_SRC + 1, cfg(0, 0, 15, 8'h41));
        pulse(8'h02);
        idle(3);
        check("R3 threshold 15 blocks", {31'd0, irq}, 32'd0);
        rd(W_ACK, d); check("R8 spurious", d, 32'h0000_00EE);
        wr(W_TASK, 32'd14);
        idle(1);
        check("R8 pending kept, R4 rise", {31'd0, irq}, 32'd1);
        rd(W_ACK, d); check("R6 vector", d, 32'h0000_0041);
        check("R6 irq dropped", {31'd0, irq}, 32'd0);
        idle(3);
        check("R7 edge cleared", {31'd0, irq}, 32'd0);
        wr(W_TASK, 32'd0);
        wr(W_EOI, 32'd0);
        wr(W_SRC + 2, cfg(1, 1, 5, 8'h22));
        src_in[2] = 1'b1;
        idle(3);
        check("R12 masked no irq", {31'd0, irq}, 32'd0);
        rd(W_ACK, d); check("R12 masked not acked", d, 32'h0000_00EE);
        src_in[2] = 1'b0;
    endtask

    task automatic t_tie();
        logic [31:0] d;
        do_reset();
        wr(W_TASK, 32'd0);
        wr(W_SRC + 3, cfg(0, 0, 6, 8'h33));
        wr(W_SRC + 5, cfg(0, 0, 9, 8'h55));
        wr(W_SRC + 6, cfg(0, 0, 9, 8'h66));
        pulse(8'h68);
        idle(1);
        check("R4 irq high", {31'd0, irq}, 32'd1);
        rd(W_ACK, d); check("R5 tie lowest index", d, 32'h0000_0055);
        idle(2);
        check("R6 equal priority blocked", {31'd0, irq}, 32'd0);
        wr(W_EOI, 32'd0);
        idle(1);
        check("R11 rise after eoi", {31'd0, irq}, 32'd1);
        rd(W_ACK, d); check("R5 second winner", d, 32'h0000_0066);
        wr(W_EOI, 32'd0);
        idle(1);
        rd(W_ACK, d); check("R5 lowest last", d, 32'h0000_0033);
        wr(W_EOI, 32'd0);
        rd(W_ACK, d); check("R8 nothing left", d, 32'h0000_00FF);
    endtask

    task automatic t_nested();
        logic [31:0] d;
        do_reset();
        wr(W_TASK, 32'd0);
        wr(W_SRC + 3, cfg(0, 0, 6, 8'h33));
        wr(W_SRC + 5, cfg(0, 0, 9, 8'h55));
        wr(W_SRC + 6, cfg(0, 0, 9, 8'h66));
        pulse(8'h08);
        idle(1);
        rd(W_ACK, d); check("R6 low first", d, 32'h0000_0033);
        pulse(8'h20);
        idle(1);
        check("R4 preempt above service", {31'd0, irq}, 32'd1);
        rd(W_ACK, d); check("R6 nested", d, 32'h0000_0055);
        pulse(8'h40);
        idle(2);
        check("R6 blocked by equal", {31'd0, irq}, 32'd0);
        wr(W_EOI, 32'd0);
        idle(1);
        check("R11 highest retired", {31'd0, irq}, 32'd1);
        rd(W_ACK, d); check("R11 next vector", d, 32'h0000_0066);
    endtask

    task automatic t_sense();
        logic [31:0] d;
        do_reset();
        wr(W_SRC + 4, cfg(0, 1, 7, 8'h44));
        wr(W_TASK, 32'd7);
        src_in[4] = 1'b1;
        idle(2);
        check("R4 equal to threshold", {31'd0, irq}, 32'd0);
        wr(W_TASK, 32'd6);
        idle(1);
        check("R4 above threshold", {31'd0, irq}, 32'd1);
        rd(W_ACK, d); check("R7 level vector", d, 32'h0000_0044);
        wr(W_EOI, 32'd0);
        idle(1);
        check("R7 level stays pending", {31'd0, irq}, 32'd1);
        rd(W_ACK, d); check("R7 level again", d, 32'h0000_0044);
        src_in[4] = 1'b0;
        wr(W_EOI, 32'd0);
        idle(2);
        check("R7 level released", {31'd0, irq}, 32'd0);
        wr(W_SRC + 1, cfg(0, 0, 7, 8'h11));
        pulse(8'h02);
        idle(1);
        rd(W_ACK, d); check("R7 edge vector", d, 32'h0000_0011);
        wr(W_EOI, 32'd0);
        idle(2);
        check("R7 edge not re-raised", {31'd0, irq}, 32'd0);
        rd(W_ACK, d); check("R8 empty", d, 32'h0000_00FF);
    endtask

    task automatic t_ack_write();
        logic [31:0] d;
        do_reset();
        wr(W_TASK, 32'd0);
        wr(W_SRC + 0, cfg(0, 0, 3, 8'h10));
        pulse(8'h01);
        idle(1);
        wr(W_ACK, 32'hFFFF_FFFF);
        check("R9 irq unaffected", {31'd0, irq}, 32'd1);
        rd(W_TASK, d); check("R9 threshold unaffected", d, 32'h0000_0000);
        rd(W_ACK, d); check("R9 source still pending", d, 32'h0000_0010);
    endtask

    initial begin
        t_reset();
        t_task_reg();
        t_mask();
        t_tie();
        t_nested();
        t_sense();
        t_ack_write();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule